// File: doc/BRIEF.md
# Windowed Reseeding Pattern Generator Controller

This block drives a self-test by splitting a pseudorandom pattern stream into windows. At the start of every window it copies one entry of a small constant seed table into a pattern shift register. The register then advances through its sequence for a fixed number of clocks. Each pattern goes to the unit under test with a valid strobe. The seeds are chosen offline so that each window reaches faults that plain pseudorandom patterns miss.

Two nested counters sequence the test. The inner counter measures how far the current window has progressed. When the inner counter wraps, the outer counter selects the next seed. When the outer counter has used every table entry, the controller stops and reports completion. Compaction of the responses happens elsewhere.

Top module: `seeded_window_bist`

## Requirements
- R1: While reset is asserted, and after reset until a start is accepted, `pat_vld` and `bist_done` are 0. `pattern` is 0 during reset.
- R2: A start accepted while idle is followed by exactly one cycle with `pat_vld` low. This is the seed load. The first valid pattern that follows equals table entry 0, which occupies bits [WIDTH-1:0] of `SEED_TABLE`.
- R3: Within a window, each valid pattern is the modular LFSR successor of the one before it. The successor of p is computed as follows: shift p left one bit and fill bit 0 with zero. If bit WIDTH-1 of p was 1, XOR the result with `POLY`, the characteristic polynomial without its top term.
- R4: Every window delivers exactly `WINDOW` consecutive valid patterns.
- R5: Consecutive windows are separated by one load cycle with `pat_vld` low. Window k begins with table entry k, which occupies bits [(k+1)*WIDTH-1:k*WIDTH].
- R6: After `NUM_SEEDS` windows, that is `NUM_SEEDS*WINDOW` valid patterns, `bist_done` rises in the cycle right after the last valid pattern.
- R7: `bist_done` stays high until the next start. A start seen while done begins a fresh test from entry 0, and `bist_done` falls in the load cycle.
- R8: A start that arrives while a test is in progress has no effect on the pattern sequence, the window lengths or the completion time.
- R9: `pat_vld` and `bist_done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| start | input | 1 | Request to begin a test; honoured only while idle or done |
| pattern | output | WIDTH | Current pattern register contents |
| pat_vld | output | 1 | High when `pattern` carries a test pattern |
| bist_done | output | 1 | High once every window has been produced |

## Verification
A wrong inner count makes a window too long or too short. This shows on the strobe at that window's first boundary, no more than `WINDOW` cycles after the load. A wrong outer count shows in one of two ways. Either the pattern after a load cycle is the wrong table entry, or completion rises one window early or late. A fault in the feedback taps corrupts the second pattern of the first window. A start that leaks into a running test shows as an extra load cycle, a restart at entry 0, or late completion.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    SWB_IDLE = 2'd0,
    SWB_LOAD = 2'd1,
    SWB_RUN  = 2'd2,
    SWB_FIN  = 2'd3
  } swb_state_e;
endpackage

// File: rtl/swb_wrap_counter.sv
module swb_wrap_counter #(
  parameter int LIMIT = 4,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] value,
  output logic          at_last
);
  logic [CW-1:0] value_d;

  assign at_last = (value == CW'(LIMIT - 1));

  always_comb begin
    value_d = value;
    if (clr)          value_d = '0;
    else if (inc)     value_d = at_last ? '0 : value + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           value <= '0;
    else if (clr || inc)  value <= value_d;
  end
endmodule

// File: rtl/swb_seed_table.sv
module swb_seed_table #(
  parameter int WIDTH = 8,
  parameter int NUM_SEEDS = 4,
  parameter logic [NUM_SEEDS*WIDTH-1:0] SEED_TABLE = '1,
  localparam int IW = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
) (
  input  logic [IW-1:0]    idx,
  output logic [WIDTH-1:0] seed
);
  logic [WIDTH-1:0] entry [NUM_SEEDS];

  for (genvar g = 0; g < NUM_SEEDS; g++) begin : g_entry
    assign entry[g] = SEED_TABLE[g*WIDTH +: WIDTH];
  end

  always_comb begin
    seed = entry[0];
    for (int i = 0; i < NUM_SEEDS; i++) begin
      if (idx == IW'(i)) seed = entry[i];
    end
  end
endmodule

// File: rtl/swb_modular_lfsr.sv
module swb_modular_lfsr #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] POLY = 8'h1D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             step_en,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] state_d;

  assign shifted = {state[WIDTH-2:0], 1'b0};

  always_comb begin
    state_d = state;
    if (load_en)       state_d = seed;
    else if (step_en)  state_d = state[WIDTH-1] ? (shifted ^ POLY) : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 state <= '0;
    else if (load_en || step_en) state <= state_d;
  end
endmodule

// File: rtl/seeded_window_bist.sv
module seeded_window_bist #(
  parameter int WIDTH = 8,
  parameter int NUM_SEEDS = 4,
  parameter int WINDOW = 6,
  parameter logic [WIDTH-1:0] POLY = 8'h1D,
  parameter logic [NUM_SEEDS*WIDTH-1:0] SEED_TABLE = 32'h01C3_5A81
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [WIDTH-1:0] pattern,
  output logic             pat_vld,
  output logic             bist_done
);
  import swb_pkg::*;

  localparam int IW = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;
  localparam int WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  swb_state_e       state_q, state_d;
  logic             start_ok;
  logic [IW-1:0]    seed_idx;
  logic             seed_last;
  logic [WW-1:0]    win_pos;
  logic             win_last;
  logic [WIDTH-1:0] seed_val;
  logic             in_load, in_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign in_load  = (state_q == SWB_LOAD);
  assign in_run   = (state_q == SWB_RUN);
  assign start_ok = start && ((state_q == SWB_IDLE) || (state_q == SWB_FIN));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SWB_IDLE, SWB_FIN: if (start) state_d = SWB_LOAD;
      SWB_LOAD:          state_d = SWB_RUN;
      SWB_RUN:           if (win_last) state_d = seed_last ? SWB_FIN : SWB_LOAD;
      default:           state_d = SWB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= SWB_IDLE;
    else            state_q <= state_d;
  end

  swb_wrap_counter #(.LIMIT(NUM_SEEDS)) u_seed_ctr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (start_ok),
    .inc     (in_run && win_last && !seed_last),
    .value   (seed_idx),
    .at_last (seed_last)
  );

  swb_wrap_counter #(.LIMIT(WINDOW)) u_win_ctr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (in_load),
    .inc     (in_run),
    .value   (win_pos),
    .at_last (win_last)
  );

  swb_seed_table #(
    .WIDTH(WIDTH), .NUM_SEEDS(NUM_SEEDS), .SEED_TABLE(SEED_TABLE)
  ) u_table (
    .idx  (seed_idx),
    .seed (seed_val)
  );

  swb_modular_lfsr #(.WIDTH(WIDTH), .POLY(POLY)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (in_load),
    .step_en (in_run),
    .seed    (seed_val),
    .state   (pattern)
  );

  assign pat_vld   = in_run;
  assign bist_done = (state_q == SWB_FIN);
endmodule

// File: rtl/seeded_window_bist_chk.sv
module seeded_window_bist_chk #(
  parameter int WIDTH = 8,
  parameter int WINDOW = 6,
  parameter logic [WIDTH-1:0] POLY = 8'h1D,
  localparam int RW = $clog2(WINDOW + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] pattern,
  input logic             pat_vld,
  input logic             bist_done
);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (pat_vld) run_len <= run_len + RW'(1);
    else              run_len <= '0;
  end

  function automatic logic [WIDTH-1:0] succ(input logic [WIDTH-1:0] p);
    logic [WIDTH-1:0] s;
    s = p << 1;
    if (p[WIDTH-1]) s = s ^ POLY;
    return s;
  endfunction

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pat_vld && bist_done));

  assert_lfsr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_vld && $past(pat_vld)) |-> (pattern == succ($past(pattern))));

  assert_window_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pat_vld |-> (run_len < RW'(WINDOW)));

  assert_window_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pat_vld) |-> (run_len == RW'(WINDOW)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_done && !start) |=> bist_done);
endmodule

bind seeded_window_bist seeded_window_bist_chk #(
  .WIDTH(WIDTH), .WINDOW(WINDOW), .POLY(POLY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .pattern   (pattern),
  .pat_vld   (pat_vld),
  .bist_done (bist_done)
);

// File: tb/seeded_window_bist_bench.sv
module seeded_window_bist_bench;
  localparam int WIDTH = 8;
  localparam int NUM_SEEDS = 4;
  localparam int WINDOW = 6;
  localparam logic [WIDTH-1:0] POLY = 8'h1D;
  localparam logic [NUM_SEEDS*WIDTH-1:0] TABLE = 32'h01C3_5A81;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [WIDTH-1:0] pattern;
  logic pat_vld, bist_done;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seeded_window_bist #(
    .WIDTH(WIDTH), .NUM_SEEDS(NUM_SEEDS), .WINDOW(WINDOW),
    .POLY(POLY), .SEED_TABLE(TABLE)
  ) u_seeded_window_bist (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pattern(pattern), .pat_vld(pat_vld), .bist_done(bist_done)
  );

  function automatic logic [WIDTH-1:0] next_pat(input logic [WIDTH-1:0] p);
    int v;
    v = int'(p) * 2;
    if (v >= (1 << WIDTH)) v = (v - (1 << WIDTH)) ^ int'(POLY);
    return WIDTH'(v);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Pulses start, then walks every load and pattern cycle; when inject >= 0,
  // start is raised again at that step of the walk to exercise R8.
  task automatic run_test(input int inject);
    int step;
    logic [WIDTH-1:0] exp;
    step = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int s = 0; s < NUM_SEEDS; s++) begin
      if (s > 0) @(negedge clk);
      chk(s == 0 ? "R2 load gap" : "R5 load gap", int'(pat_vld), 0);
      chk("R7 done low while running", int'(bist_done), 0);
      start = (step == inject); step++;
      exp = TABLE[s*WIDTH +: WIDTH];
      for (int j = 0; j < WINDOW; j++) begin
        @(negedge clk);
        chk("R4 strobe inside window", int'(pat_vld), 1);
        if (j == 0) chk(s == 0 ? "R2 first seed" : "R5 next seed", int'(pattern), int'(exp));
        else        chk("R3 lfsr successor", int'(pattern), int'(exp));
        chk("R9 done with strobe", int'(bist_done), 0);
        if (inject >= 0) chk("R8 start ignored", int'(pattern), int'(exp));
        exp = next_pat(exp);
        start = (step == inject); step++;
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk("R6 done after last pattern", int'(bist_done), 1);
    chk("R4 window closed", int'(pat_vld), 0);
    repeat (5) begin
      @(negedge clk);
      chk("R7 done held", int'(bist_done), 1);
      chk("R9 no strobe when done", int'(pat_vld), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset strobe", int'(pat_vld), 0);
    chk("R1 reset done", int'(bist_done), 0);
    chk("R1 reset pattern", int'(pattern), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk("R1 idle strobe", int'(pat_vld), 0);
      chk("R1 idle done", int'(bist_done), 0);
    end
    run_test(-1);
    run_test(-1);
    run_test(3);
    run_test(WINDOW);
    run_test(2 * WINDOW + 1);
    // Abort a test with reset and begin again from the first seed.
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-run strobe", int'(pat_vld), 0);
    chk("R1 reset mid-run pattern", int'(pattern), 0);
    chk("R1 reset mid-run done", int'(bist_done), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'(pat_vld), 0);
    run_test(-1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule